// File: doc/BRIEF.md
# Software-Triggered Interrupt Pulse Generator

This block turns one write to the distributor's software-trigger register (offset 0xF00, an action on write that keeps no state) into set-pending pulses. A write carries a software interrupt ID, an explicit list of target CPUs, a two-bit filter and a security attribute. The filter chooses the CPUs to signal:

- the explicit list;
- every CPU except the one that issued the write;
- the issuing CPU alone;
- nobody, for the reserved code.

For each chosen CPU, the block raises the bit for the selected ID in a flat per-CPU, per-ID pulse vector. That vector drives the distributor's pending logic.

The pending stage keeps one bit per CPU and ID. Pulses that arrive before that bit is acknowledged merge into it, so the generator queues nothing. The security attribute goes out next to the pulses and has no effect on them. Delivery, priority and acknowledgement are handled elsewhere.

Top module: `swi_trigger_gen`

## Requirements
- R1: While reset is asserted, and in the first cycle after reset is released, `pend_set_o` and `sec_attr_o` are all zero.
- R2: A write sampled with `wr_en_i` high on a clock edge drives its pulses for exactly the next cycle. A cycle whose preceding edge saw no write has `pend_set_o` all zero.
- R3: Write bits 3:0 hold the interrupt ID. For a targeted CPU c and ID s, the pulse is bit `c*NUM_SWI + s` of `pend_set_o`.
- R4: Filter code 2'b00 in bits 25:24 targets the CPUs whose bits are set in the list in bits 23:16, where bit 16+n selects CPU n. An empty list gives no pulses.
- R5: Filter code 2'b01 targets every CPU except the one numbered `req_cpu_i`, and the list bits are ignored.
- R6: Filter code 2'b10 targets only the CPU numbered `req_cpu_i`, and the list bits are ignored.
- R7: Filter code 2'b11 is reserved and produces no pulses.
- R8: In the pulse cycle, `sec_attr_o` equals bit 15 of the write, where 0 means a secure request. It is 0 whenever no pulse is raised. The attribute never changes which pulses are raised.
- R9: Write bits 14:4 and 31:26 have no effect on the outputs.
- R10: Writes on consecutive cycles each produce their own pulse vector, one cycle after each write, with no merging and no loss.
- R11: In any cycle, at most one ID bit is raised for each CPU.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk_i | input | 1 | Clock |
| rst_ni | input | 1 | Active-low asynchronous reset |
| wr_en_i | input | 1 | Write strobe for the trigger register |
| wr_data_i | input | 32 | Trigger register write data |
| req_cpu_i | input | REQ_W (3) | Number of the CPU issuing the write |
| pend_set_o | output | NUM_CPU*NUM_SWI (128) | One-cycle set-pending pulses, bit c*NUM_SWI+s for CPU c and ID s |
| sec_attr_o | output | 1 | Security attribute of the write that caused the current pulses |

## Verification
Some rules are checked by the assertions on every cycle:

- there are no pulses without a preceding write;
- there is at most one ID per CPU;
- the reserved filter and an empty list stay silent;
- the requester is excluded under the all-but-self filter;
- exactly one pulse is raised under the self filter;
- the attribute is low when nothing fires.

Other behaviour can only be shown by the bench's scenarios:

- the exact CPU masks for given lists and requesters;
- the bit index at which an ID lands;
- ignored write bits leave the result unchanged;
- the pass-through value of the attribute;
- back-to-back writes stay apart.

// File: rtl/swi_pkg.sv
package swi_pkg;
  // trigger register field layout (decoded by software-visible format)
  localparam int unsigned ID_LSB    = 0;
  localparam int unsigned NSEC_BIT  = 15;
  localparam int unsigned LIST_LSB  = 16;
  localparam int unsigned LIST_MAXW = 8;
  localparam int unsigned FILT_LSB  = 24;

  typedef enum logic [1:0] {
    FILT_LIST   = 2'b00,
    FILT_OTHERS = 2'b01,
    FILT_SELF   = 2'b10,
    FILT_NONE   = 2'b11
  } filt_e;
endpackage

// File: rtl/swi_decode.sv
module swi_decode
  import swi_pkg::*;
#(
  parameter int unsigned NUM_CPU = 8,
  parameter int unsigned ID_W    = 4
) (
  input  logic [31:0]        wr_data_i,
  output filt_e              filt_o,
  output logic [NUM_CPU-1:0] list_o,
  output logic [ID_W-1:0]    id_o,
  output logic               nsec_o
);
  assign filt_o = filt_e'(wr_data_i[FILT_LSB +: 2]);
  assign list_o = wr_data_i[LIST_LSB +: NUM_CPU];
  assign id_o   = wr_data_i[ID_LSB +: ID_W];
  assign nsec_o = wr_data_i[NSEC_BIT];
endmodule

// File: rtl/swi_target_sel.sv
module swi_target_sel
  import swi_pkg::*;
#(
  parameter int unsigned NUM_CPU = 8,
  parameter int unsigned REQ_W   = 3
) (
  input  filt_e              filt_i,
  input  logic [NUM_CPU-1:0] list_i,
  input  logic [REQ_W-1:0]   req_cpu_i,
  output logic [NUM_CPU-1:0] mask_o
);
  logic [NUM_CPU-1:0] self_m;

  for (genvar c = 0; c < NUM_CPU; c++) begin : g_self
    assign self_m[c] = (req_cpu_i == REQ_W'(c));
  end

  always_comb begin
    unique case (filt_i)
      FILT_LIST:   mask_o = list_i;
      FILT_OTHERS: mask_o = ~self_m;
      FILT_SELF:   mask_o = self_m;
      default:     mask_o = '0;
    endcase
  end
endmodule

// File: rtl/swi_pulse_reg.sv
module swi_pulse_reg #(
  parameter int unsigned NUM_CPU = 8,
  parameter int unsigned NUM_SWI = 16,
  parameter int unsigned ID_W    = 4
) (
  input  logic                       clk_i,
  input  logic                       rst_ni,
  input  logic                       fire_i,
  input  logic [NUM_CPU-1:0]         mask_i,
  input  logic [ID_W-1:0]            id_i,
  input  logic                       nsec_i,
  output logic [NUM_CPU*NUM_SWI-1:0] pend_set_o,
  output logic                       sec_attr_o
);
  logic [NUM_SWI-1:0]         id_oh;
  logic [NUM_CPU*NUM_SWI-1:0] pend_d;
  logic                       sec_d;

  for (genvar s = 0; s < NUM_SWI; s++) begin : g_id
    assign id_oh[s] = (id_i == ID_W'(s));
  end

  for (genvar c = 0; c < NUM_CPU; c++) begin : g_cpu
    assign pend_d[c*NUM_SWI +: NUM_SWI] = (fire_i && mask_i[c]) ? id_oh : '0;
  end

  assign sec_d = fire_i & nsec_i & (|mask_i);

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      pend_set_o <= '0;
      sec_attr_o <= 1'b0;
    end else begin
      pend_set_o <= pend_d;
      sec_attr_o <= sec_d;
    end
  end
endmodule

// File: rtl/swi_trigger_gen.sv
module swi_trigger_gen
  import swi_pkg::*;
#(
  parameter int unsigned NUM_CPU = 8,
  parameter int unsigned NUM_SWI = 16,
  localparam int unsigned REQ_W  = (NUM_CPU > 1) ? $clog2(NUM_CPU) : 1,
  localparam int unsigned ID_W   = (NUM_SWI > 1) ? $clog2(NUM_SWI) : 1,
  localparam int unsigned PEND_W = NUM_CPU * NUM_SWI
) (
  input  logic              clk_i,
  input  logic              rst_ni,
  input  logic              wr_en_i,
  input  logic [31:0]       wr_data_i,
  input  logic [REQ_W-1:0]  req_cpu_i,
  output logic [PEND_W-1:0] pend_set_o,
  output logic              sec_attr_o
);
  filt_e              filt;
  logic [NUM_CPU-1:0] list;
  logic [NUM_CPU-1:0] mask;
  logic [ID_W-1:0]    id;
  logic               nsec;

  swi_decode #(.NUM_CPU(NUM_CPU), .ID_W(ID_W)) u_dec (
    .wr_data_i (wr_data_i),
    .filt_o    (filt),
    .list_o    (list),
    .id_o      (id),
    .nsec_o    (nsec)
  );

  swi_target_sel #(.NUM_CPU(NUM_CPU), .REQ_W(REQ_W)) u_sel (
    .filt_i    (filt),
    .list_i    (list),
    .req_cpu_i (req_cpu_i),
    .mask_o    (mask)
  );

  swi_pulse_reg #(.NUM_CPU(NUM_CPU), .NUM_SWI(NUM_SWI), .ID_W(ID_W)) u_pulse (
    .clk_i      (clk_i),
    .rst_ni     (rst_ni),
    .fire_i     (wr_en_i),
    .mask_i     (mask),
    .id_i       (id),
    .nsec_i     (nsec),
    .pend_set_o (pend_set_o),
    .sec_attr_o (sec_attr_o)
  );
endmodule

// File: rtl/swi_trigger_chk.sv
module swi_trigger_chk
  import swi_pkg::*;
#(
  parameter int unsigned NUM_CPU = 8,
  parameter int unsigned NUM_SWI = 16,
  localparam int unsigned REQ_W  = (NUM_CPU > 1) ? $clog2(NUM_CPU) : 1,
  localparam int unsigned PEND_W = NUM_CPU * NUM_SWI
) (
  input logic              clk_i,
  input logic              rst_ni,
  input logic              wr_en_i,
  input logic [31:0]       wr_data_i,
  input logic [REQ_W-1:0]  req_cpu_i,
  input logic [PEND_W-1:0] pend_set_o,
  input logic              sec_attr_o
);
  logic [REQ_W-1:0]   req_q;
  logic [NUM_SWI-1:0] self_slice;
  logic [1:0]         filt_in;

  assign filt_in = wr_data_i[FILT_LSB +: 2];

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) req_q <= '0;
    else         req_q <= req_cpu_i;
  end

  always_comb begin
    self_slice = '0;
    for (int c = 0; c < NUM_CPU; c++)
      if (req_q == REQ_W'(c)) self_slice = pend_set_o[c*NUM_SWI +: NUM_SWI];
  end

  assert_idle_quiet_R2: assert property (@(posedge clk_i) disable iff (!rst_ni)
    !wr_en_i |=> pend_set_o == '0);

  assert_reserved_silent_R7: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (wr_en_i && filt_in == 2'b11) |=> pend_set_o == '0);

  assert_empty_list_R4: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (wr_en_i && filt_in == 2'b00 && wr_data_i[LIST_LSB +: NUM_CPU] == '0) |=> pend_set_o == '0);

  assert_skip_requester_R5: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (wr_en_i && filt_in == 2'b01) |=> self_slice == '0);

  assert_self_only_R6: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (wr_en_i && filt_in == 2'b10) |=> ($countones(pend_set_o) == 1 && self_slice != '0));

  assert_attr_quiet_R8: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (pend_set_o == '0) |-> !sec_attr_o);

  for (genvar c = 0; c < NUM_CPU; c++) begin : g_oh
    assert_one_id_R11: assert property (@(posedge clk_i) disable iff (!rst_ni)
      $onehot0(pend_set_o[c*NUM_SWI +: NUM_SWI]));
  end
endmodule

bind swi_trigger_gen swi_trigger_chk #(.NUM_CPU(NUM_CPU), .NUM_SWI(NUM_SWI)) u_chk (
  .clk_i      (clk_i),
  .rst_ni     (rst_ni),
  .wr_en_i    (wr_en_i),
  .wr_data_i  (wr_data_i),
  .req_cpu_i  (req_cpu_i),
  .pend_set_o (pend_set_o),
  .sec_attr_o (sec_attr_o)
);

// File: tb/sim_swi_trigger_gen.sv
`timescale 1ns/1ps
module sim_swi_trigger_gen;
  localparam int NCPU = 8;
  localparam int NSWI = 16;
  localparam int PW   = NCPU * NSWI;
  localparam int NV   = 10;

  typedef struct packed {
    logic [31:0] data;
    logic [2:0]  req;
    logic [7:0]  mask;
    logic [3:0]  id;
    logic        sec;
  } vec_t;

  localparam vec_t VECS [NV] = '{
    '{32'h0000_0005, 3'd0, 8'h00, 4'd5,  1'b0},  // R4 empty list
    '{32'h0001_0003, 3'd2, 8'h01, 4'd3,  1'b0},  // R4 single cpu
    '{32'h00A5_000F, 3'd1, 8'hA5, 4'd15, 1'b0},  // R4 R3 top id
    '{32'h01FF_0002, 3'd3, 8'hF7, 4'd2,  1'b0},  // R5
    '{32'h0100_0007, 3'd0, 8'hFE, 4'd7,  1'b0},  // R5 list ignored
    '{32'h0200_0009, 3'd5, 8'h20, 4'd9,  1'b0},  // R6
    '{32'h02FF_8001, 3'd7, 8'h80, 4'd1,  1'b1},  // R6 R8
    '{32'h03FF_8004, 3'd2, 8'h00, 4'd4,  1'b0},  // R7
    '{32'hFC42_7FF6, 3'd4, 8'h42, 4'd6,  1'b0},  // R9 junk bits
    '{32'h0081_8000, 3'd6, 8'h81, 4'd0,  1'b1}   // R8 R3 id zero
  };

  logic          clk_i = 1'b0;
  logic          rst_ni = 1'b0;
  logic          wr_en_i = 1'b0;
  logic [31:0]   wr_data_i = '0;
  logic [2:0]    req_cpu_i = '0;
  logic [PW-1:0] pend_set_o;
  logic          sec_attr_o;

  int n_chk = 0;
  int n_fail = 0;

  always #10 clk_i = ~clk_i;

  swi_trigger_gen #(.NUM_CPU(NCPU), .NUM_SWI(NSWI)) u0 (
    .clk_i(clk_i), .rst_ni(rst_ni), .wr_en_i(wr_en_i), .wr_data_i(wr_data_i),
    .req_cpu_i(req_cpu_i), .pend_set_o(pend_set_o), .sec_attr_o(sec_attr_o)
  );

  function automatic logic [PW-1:0] build(input logic [7:0] mask, input logic [3:0] id);
    logic [PW-1:0] r = '0;
    for (int c = 0; c < NCPU; c++)
      if (mask[c]) r[c*NSWI + int'(id)] = 1'b1;
    return r;
  endfunction

  task automatic chk(input string tag, input logic [PW-1:0] act, input logic [PW-1:0] exp);
    n_chk++;
    if (act !== exp) begin
      n_fail++;
      $display("FAIL %s act=%h exp=%h", tag, act, exp);
    end
  endtask

  task automatic chk1(input string tag, input logic act, input logic exp);
    n_chk++;
    if (act !== exp) begin
      n_fail++;
      $display("FAIL %s act=%b exp=%b", tag, act, exp);
    end
  endtask

  task automatic drive(input logic [31:0] d, input logic [2:0] r);
    wr_en_i = 1'b1; wr_data_i = d; req_cpu_i = r;
  endtask

  initial begin
    #(20 * 20000);
    n_fail++; n_chk++;
    $display("FAIL watchdog act=timeout exp=done");
    $display("%0d/%0d checks passed", n_chk - n_fail, n_chk);
    $finish;
  end

  initial begin
    repeat (3) @(negedge clk_i);
    chk("R1 pend in reset", pend_set_o, '0);
    chk1("R1 attr in reset", sec_attr_o, 1'b0);
    rst_ni = 1'b1;
    @(negedge clk_i);
    chk("R1 pend after reset", pend_set_o, '0);
    chk1("R1 attr after reset", sec_attr_o, 1'b0);

    for (int i = 0; i < NV; i++) begin
      drive(VECS[i].data, VECS[i].req);
      @(negedge clk_i);
      wr_en_i = 1'b0;
      wr_data_i = '0;
      chk($sformatf("R3 R4 R5 R6 R7 R9 vec%0d pend", i), pend_set_o, build(VECS[i].mask, VECS[i].id));
      chk1($sformatf("R8 vec%0d attr", i), sec_attr_o, VECS[i].sec);
      @(negedge clk_i);
      chk($sformatf("R2 vec%0d pulse ends", i), pend_set_o, '0);
    end

    // R10 back-to-back writes
    drive(32'h0003_0004, 3'd0);
    @(negedge clk_i);
    chk("R10 first write", pend_set_o, build(8'h03, 4'd4));
    drive(32'h0100_800B, 3'd1);
    @(negedge clk_i);
    chk("R10 second write", pend_set_o, build(8'hFD, 4'd11));
    chk1("R10 R8 second attr", sec_attr_o, 1'b1);
    drive(32'h0003_0004, 3'd0);
    @(negedge clk_i);
    wr_en_i = 1'b0;
    chk("R10 repeat write", pend_set_o, build(8'h03, 4'd4));
    chk1("R8 third attr", sec_attr_o, 1'b0);
    @(negedge clk_i);
    chk("R2 idle after burst", pend_set_o, '0);

    // R2 data without strobe
    wr_data_i = 32'h00FF_000A;
    @(negedge clk_i);
    chk("R2 data without strobe", pend_set_o, '0);

    // R1 reset mid-pulse
    drive(32'h00FF_8001, 3'd0);
    @(negedge clk_i);
    wr_en_i = 1'b0;
    rst_ni = 1'b0;
    #1;
    chk("R1 async clear", pend_set_o, '0);
    chk1("R1 async clear attr", sec_attr_o, 1'b0);
    @(negedge clk_i);
    rst_ni = 1'b1;
    @(negedge clk_i);

    $display("%0d/%0d checks passed", n_chk - n_fail, n_chk);
    $finish;
  end
endmodule